// File: doc/BRIEF.md
# Serial Transmit Unit with FIFO and Break

This block is the sending half of a register-mapped UART. Software writes characters through a simple 32-bit bus into an eight-entry queue. A serializer takes them one at a time and drives the serial line. The line idles high. Each frame is a low start bit, eight data bits least significant first, an optional parity bit, and one or two high stop bits. Every bit lasts `(divisor + 1) * 16` clock cycles.

A mode register holds the frame settings, the module-on gate, loopback and a clear-to-send flow gate. A control/status register holds the transmit enable, the break request and the interrupt policy. It also reports two flags: "queue full" and "transmitter fully drained".

- In loopback, frames go to an internal receive tap and the external line stays high.
- A break request sends an all-low frame once the character in progress has finished.
- The interrupt output pulses for one cycle on one of three events, chosen by software: the queue emptying, the transmitter draining, or the queue leaving full.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset the mode register (address 0x00) reads 0, the control register (0x10) reads 0x100 (only the drained flag, bit 8, set), the divisor (0x40) reads 0, `txd` and `rx_tap` are high and `tx_irq` is low.
- R2: With mode bits [2:1] = 00 and mode bit 0 clear, a queued byte is sent as one low start bit, then data bits from bit 0 to bit 7, then one high stop bit.
- R3: Each bit is held on the line for (divisor + 1) * 16 clock cycles, where the divisor is the value written to address 0x40.
- R4: Mode bits [2:1] = 01 add an even parity bit after data bit 7, and 10 add an odd parity bit there. Even parity makes the count of ones over data and parity even; odd parity makes it odd.
- R5: With mode bit 0 set, two stop bits are sent. For two back-to-back queued frames, the spacing from one start edge to the next is (frame bits) * (bit length) + 1 cycles.
- R6: The queue holds 8 bytes, written at address 0x20. Control bit 9 reads 1 while it is full. A write while it is full is dropped, and the queued bytes go out in write order.
- R7: Control bit 8 reads 1 only when the queue is empty and the last stop bit has completed. It reads 0 while data waits or a frame is on the line.
- R8: No frame starts unless both mode bit 15 (module on) and control bit 10 (transmit enable) are set. Queued data is kept while either is clear and is sent once both are set.
- R9: While control bit 11 is set, the character in progress finishes first. Then all-low frames of the current frame length are sent for as long as the bit stays set. A break frame that has started always completes.
- R10: With mode bit 6 set, frames appear on `rx_tap` and `txd` stays high. Otherwise `rx_tap` stays high.
- R11: Control bits [15:14] pick the interrupt event. With bit 15 = 0, `tx_irq` pulses once when the queue becomes empty, in the first cycle of the start bit. With 10, it pulses when the transmitter has drained, with the line high. With 11, it pulses when a full queue gives up an entry.
- R12: With mode bit 9 set, a new data frame starts only while `cts_n` is low. A frame is held back while `cts_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cts_n | input | 1 | Clear-to-send, active low, used when flow gating is on |
| txd | output | 1 | Serial transmit line |
| rx_tap | output | 1 | Internal receive tap, carries frames in loopback |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
The hardest situation to reach is the break request that arrives while a character is on the line and is then withdrawn partway through the break frame. The bench starts a byte and raises the break bit in a parallel thread, 40 cycles into that frame. It checks that the byte still arrives intact. It then clears the break bit 20 cycles into the break and checks two things: the low stretch lasts exactly one full frame, and no second break follows. The queue-full case is reached by filling the queue with the transmit enable clear, so that nothing drains while the ninth write is attempted.

// File: rtl/serial_tx_unit.sv
module serial_tx_unit #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  output logic [31:0] bus_rdata,
  input  logic        cts_n,
  output logic        txd,
  output logic        rx_tap,
  output logic        tx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = DIV_W + 5;
  localparam logic [7:0] A_MODE = 8'h00, A_CTRL = 8'h10, A_TXD = 8'h20, A_DIV = 8'h40;

  logic [15:0]      mode_q, ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             busy;
  logic [11:0]      sh;
  logic [3:0]       left;
  logic [BW-1:0]    tcnt;

  wire on     = mode_q[15];
  wire flow   = mode_q[9];
  wire lpbk   = mode_q[6];
  wire par_en = mode_q[2] ^ mode_q[1];
  wire par_od = mode_q[2];
  wire stop2  = mode_q[0];
  wire txen   = ctrl_q[10];
  wire brk    = ctrl_q[11];

  wire empty = (cnt == '0);
  wire full  = (cnt == CW'(DEPTH));
  wire idle  = empty && !busy;

  wire [BW-1:0] bit_len = BW'({div_q, 4'b0000}) + BW'(16);
  wire tick = busy && (tcnt == bit_len - BW'(1));
  wire last = on && tick && (left == 4'd1);
  wire go   = !busy && on && txen && (brk || (!empty && (!flow || !cts_n)));
  wire pop  = go && !brk;
  wire push = bus_we && (bus_addr == A_TXD) && !full;

  wire [7:0]  head   = mem[rp];
  wire        parity = ^head ^ par_od;
  wire [3:0]  nbits  = 4'd10 + {3'b000, par_en} + {3'b000, stop2};
  wire [11:0] frame  = brk ? 12'h000 :
                       par_en ? {2'b11, parity, head, 1'b0} : {3'b111, head, 1'b0};

  wire ser = busy ? sh[0] : 1'b1;
  assign txd    = lpbk ? 1'b1 : ser;
  assign rx_tap = lpbk ? ser : 1'b1;

  wire ev_empty = pop && !push && (cnt == CW'(1));
  wire ev_idle  = last && empty && !push;
  wire ev_space = pop && full;
  wire irq_d    = ctrl_q[15] ? (ctrl_q[14] ? ev_space : ev_idle) : ev_empty;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {16'h0, mode_q};
      A_CTRL:  bus_rdata = {16'h0, ctrl_q[15:10], full, idle, 8'h00};
      A_DIV:   bus_rdata = 32'(div_q);
      default: bus_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_MODE) mode_q <= bus_wdata[15:0] & 16'h8247;
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[15:0] & 16'hCC00;
      if (bus_addr == A_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else if (!on) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (go) begin
      busy <= 1'b1;
      sh   <= frame;
      left <= nbits;
      tcnt <= '0;
    end else if (busy) begin
      if (tick) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[11:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_irq <= 1'b0;
    else        tx_irq <= irq_d;
  end

  // R6
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_TXD && full && !pop) |=> full);
  // R8
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(on && txen)) |=> !busy);
  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && on) |-> ($past(left) == 4'd1));
  // R9
  brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && brk) |=> (busy && ser == 1'b0));
  // R11
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == CW'(1) && !ctrl_q[15]) |=> tx_irq);
  // R12
  cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && flow && cts_n && !brk) |=> !busy);
endmodule

// File: tb/sim_serial_tx_unit.sv
`timescale 1ns/1ps
module sim_serial_tx_unit;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, cts_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0, bus_rdata;
  logic txd, rx_tap, tx_irq;
  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, txd_low = 0;
  logic irq_line = 1'b1;

  serial_tx_unit u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cts_n(cts_n), .txd(txd), .rx_tap(rx_tap),
    .tx_irq(tx_irq));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tx_irq) begin irq_cnt++; irq_line = txd; end
    if (!txd) txd_low++;
  end

  localparam logic [7:0] MODE = 8'h00, CTRL = 8'h10, TXR = 8'h20, DIVR = 8'h40;
  localparam logic [31:0] ON = 32'h8000, TXEN = 32'h0400, BRK = 32'h0800;
  int bl = 16;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic line(input bit tap);
    return tap ? rx_tap : txd;
  endfunction

  task automatic rx_frame(input bit tap, input int nb, output logic [11:0] bits);
    bits = '1;
    do @(negedge clk); while (line(tap) !== 1'b0);
    repeat (bl / 2) @(negedge clk);
    bits[0] = line(tap);
    for (int i = 1; i < nb; i++) begin
      repeat (bl) @(negedge clk);
      bits[i] = line(tap);
    end
  endtask

  task automatic low_len(output int n);
    do @(negedge clk); while (txd !== 1'b0);
    n = 1;
    forever begin
      @(negedge clk);
      if (txd === 1'b0) n++; else break;
    end
  endtask

  task automatic gap(output int n);
    logic seen_high;
    do @(negedge clk); while (txd !== 1'b0);
    n = 0; seen_high = 1'b0;
    forever begin
      @(negedge clk); n++;
      if (txd === 1'b1) seen_high = 1'b1;
      else if (seen_high) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [11:0] f;
    int n, base;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(MODE, r); chk("R1 mode", r, 32'h0);
    rd(CTRL, r); chk("R1 ctrl", r, 32'h100);
    rd(DIVR, r); chk("R1 div", r, 32'h0);
    chk("R1 lines", {29'h0, txd, rx_tap, tx_irq}, 32'h6);

    // R2 all bytes 8N1
    wr(MODE, ON); wr(CTRL, TXEN);
    for (int v = 0; v < 256; v++) begin
      b = 8'(v);
      wr(TXR, {24'h0, b});
      rx_frame(1'b0, 10, f);
      chk("R2 frame", {22'h0, f[9:0]}, {22'h0, 1'b1, b, 1'b0});
    end
    repeat (bl) @(negedge clk);

    // R3 bit length for divisor 0..3
    for (int d = 0; d < 4; d++) begin
      wr(DIVR, d);
      wr(TXR, 32'h01);
      low_len(n);
      chk("R3 bit length", n, (d + 1) * 16);
      repeat (10 * (d + 1) * 16) @(negedge clk);
    end
    wr(DIVR, 0); bl = 16;

    // R4 even and odd parity
    for (int m = 1; m <= 2; m++) begin
      wr(MODE, ON | (m << 1));
      for (int v = 0; v < 64; v++) begin
        b = 8'(v * 37 + 5);
        wr(TXR, {24'h0, b});
        rx_frame(1'b0, 11, f);
        chk(m == 1 ? "R4 even" : "R4 odd", {21'h0, f[10:0]},
            {21'h0, 1'b1, (^b) ^ (m == 2), b, 1'b0});
      end
      repeat (bl) @(negedge clk);
    end

    // R5 start-to-start spacing, 8N1, 8N2, 8E2
    for (int k = 0; k < 3; k++) begin
      int mbits, fb;
      mbits = (k == 0) ? 0 : (k == 1) ? 1 : 3;
      fb = (k == 0) ? 10 : (k == 1) ? 11 : 12;
      wr(CTRL, 0); wr(MODE, ON | mbits);
      wr(TXR, 0); wr(TXR, 0);
      wr(CTRL, TXEN);
      gap(n);
      chk("R5 spacing", n, fb * 16 + 1);
      repeat (14 * 16) @(negedge clk);
    end

    // R6 full flag, drop, order; R7 drained flag
    wr(MODE, ON); wr(CTRL, 0);
    for (int i = 0; i < 9; i++) wr(TXR, 32'hA0 + i);
    rd(CTRL, r); chk("R6 full flag", r[9:8], 2'b10);
    wr(CTRL, TXEN);
    for (int i = 0; i < 8; i++) begin
      rx_frame(1'b0, 10, f);
      chk("R6 order", f[8:1], 8'hA0 + i);
    end
    rd(CTRL, r); chk("R7 busy during stop", r[8], 1'b0);
    base = txd_low;
    repeat (400) @(negedge clk);
    chk("R6 ninth dropped", txd_low - base, 0);
    rd(CTRL, r); chk("R7 drained", r[9:8], 2'b01);

    // R8 module off and enable off gates
    wr(MODE, 0); wr(CTRL, TXEN); wr(TXR, 32'h3C);
    base = txd_low; repeat (300) @(negedge clk);
    chk("R8 off holds", txd_low - base, 0);
    rd(CTRL, r); chk("R8 data kept", r[8], 1'b0);
    wr(CTRL, 0); wr(MODE, ON);
    base = txd_low; repeat (300) @(negedge clk);
    chk("R8 txen holds", txd_low - base, 0);
    wr(CTRL, TXEN);
    rx_frame(1'b0, 10, f); chk("R8 released", f[8:1], 8'h3C);
    repeat (bl) @(negedge clk);

    // R12 clear-to-send gate
    cts_n = 1'b1;
    wr(MODE, ON | 32'h200); wr(TXR, 32'h96);
    base = txd_low; repeat (300) @(negedge clk);
    chk("R12 held", txd_low - base, 0);
    cts_n = 1'b0;
    rx_frame(1'b0, 10, f); chk("R12 sent", f[8:1], 8'h96);
    repeat (bl) @(negedge clk);
    wr(MODE, ON);

    // R10 loopback
    wr(MODE, ON | 32'h40);
    base = txd_low;
    wr(TXR, 32'h5A);
    rx_frame(1'b1, 10, f); chk("R10 tap frame", {22'h0, f[9:0]}, {22'h0, 1'b1, 8'h5A, 1'b0});
    chk("R10 txd quiet", txd_low - base, 0);
    repeat (bl) @(negedge clk);
    wr(MODE, ON);

    // R9 break after character, withdrawn mid-break
    wr(TXR, 32'h55);
    fork
      rx_frame(1'b0, 10, f);
      begin repeat (40) @(negedge clk); wr(CTRL, TXEN | BRK); end
    join
    chk("R9 char first", {22'h0, f[9:0]}, {22'h0, 1'b1, 8'h55, 1'b0});
    fork
      low_len(n);
      begin
        do @(negedge clk); while (txd !== 1'b0);
        repeat (20) @(negedge clk);
        wr(CTRL, TXEN);
      end
    join
    chk("R9 break length", n, 160);
    base = txd_low; repeat (300) @(negedge clk);
    chk("R9 break ends", txd_low - base, 0);

    // R11 interrupt policies
    base = irq_cnt;
    wr(CTRL, TXEN); wr(TXR, 32'h11);
    rx_frame(1'b0, 10, f); repeat (2 * bl) @(negedge clk);
    chk("R11 empty count", irq_cnt - base, 1);
    chk("R11 empty at start", irq_line, 1'b0);
    base = irq_cnt;
    wr(CTRL, TXEN | 32'h8000); wr(TXR, 32'h22);
    rx_frame(1'b0, 10, f); repeat (2 * bl) @(negedge clk);
    chk("R11 drained count", irq_cnt - base, 1);
    chk("R11 drained line high", irq_line, 1'b1);
    base = irq_cnt;
    wr(CTRL, 32'hC000);
    for (int i = 0; i < 8; i++) wr(TXR, i);
    wr(CTRL, 32'hC000 | TXEN);
    for (int i = 0; i < 8; i++) rx_frame(1'b0, 10, f);
    repeat (2 * bl) @(negedge clk);
    chk("R11 space count", irq_cnt - base, 1);
    chk("R11 space at first start", irq_line, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule